// File: doc/BRIEF.md
# Banked Sector Transfer Splitter

This block turns one multi-sector read or write request into a sequence of card-level chunks. The request gives a start sector, a sector count, a direction, whether the target is the internal (banked) drive and whether the card addresses in sectors (high capacity) or in bytes. For every chunk the block presents a multiple-block command code, a card address and a length, and holds them until the data path signals that the chunk has completed. Each completion is followed by a one-cycle stop-transmission strobe.

Three independent limits clip each chunk: a length-register cap, a staging-buffer cap and, for the internal drive, the bank boundary. For the internal drive a fixed offset is first added to the start sector. The bank number is then found by repeated subtraction of the bank size, and the card address becomes the remainder. When the bank differs from the one last selected, a bank-select handshake runs before the chunk. A failed chunk is retried unchanged. A run of consecutive failures longer than the configured limit ends the request with a fatal strobe.

Top module: `sector_splitter`

## Requirements
- R1: Every chunk length is non-zero and no larger than the smallest of the remaining count, the register cap (127) and the staging-buffer cap (10).
- R2: For an internal-drive request, the fixed offset (0x5000 by default) is added to the start sector. The bank is that sector divided by 0x7A7800, and the address is the remainder. External requests use the start sector directly with no banking.
- R3: A bank-select handshake (`bank_sel_valid` held with `bank_sel_num` until `bank_sel_done`) happens only when the computed bank differs from the bank currently selected, which is 0 after reset. It is never active together with a chunk.
- R4: On the internal drive a chunk never extends past the end of its bank.
- R5: For a high-capacity card `chunk_addr` is the sector address. For a standard-capacity card it is that address multiplied by 512.
- R6: `chunk_cmd` is 18 for reads and 25 for writes. Exactly one cycle of `stop_valid` with `stop_cmd` = 12 follows every chunk completion.
- R7: While `chunk_valid` is high and `chunk_done` is low, the chunk address, length and command stay stable.
- R8: A completion without `chunk_err` advances the sector and remaining count by the chunk length and clears the consecutive-error count. A completion with `chunk_err` repeats the same chunk.
- R9: Ten consecutive errors are still retried. The eleventh ends the request with a one-cycle `req_fatal` after its stop strobe, with no `req_done` and no further chunk.
- R10: A request with a count of zero produces `req_done` without any chunk or stop.
- R11: After reset the block is idle: `busy`, `chunk_valid`, `bank_sel_valid`, `stop_valid`, `req_done` and `req_fatal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_start | input | 32 | First sector of the request |
| req_count | input | 16 | Number of sectors |
| req_write | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | Target is the internal banked drive |
| req_hc | input | 1 | Card addresses in sectors (high capacity) |
| busy | output | 1 | A request is in progress |
| bank_sel_valid | output | 1 | Bank-select request |
| bank_sel_num | output | 10 | Bank to select |
| bank_sel_done | input | 1 | Bank select finished |
| chunk_valid | output | 1 | Chunk descriptor valid |
| chunk_cmd | output | 6 | Multiple-block command code |
| chunk_addr | output | 32 | Card address of the chunk |
| chunk_len | output | 7 | Chunk length in sectors |
| chunk_done | input | 1 | Chunk completed |
| chunk_err | input | 1 | Completed chunk failed |
| stop_valid | output | 1 | Stop-transmission strobe |
| stop_cmd | output | 6 | Stop command code |
| req_done | output | 1 | Request finished successfully |
| req_fatal | output | 1 | Request abandoned after too many errors |

## Verification
On every cycle the assertions check the length bounds of a presented chunk and the bank-boundary clip on the internal drive. They also check that the descriptor holds steady until it is accepted, that a stop strobe only follows an accepted chunk, that a bank select and a chunk are never presented together, and that done and fatal never coincide. Only the directed scenarios can show the values themselves. These are the bank arithmetic with the drive offset, the suppression of a redundant bank select, the byte conversion for standard-capacity cards, the retry of an identical chunk, and the exact error count at which the fatal strobe appears.

// File: rtl/sector_split_pkg.sv
package sector_split_pkg;

    localparam int unsigned SECTOR_W         = 32;
    localparam int unsigned COUNT_W          = 16;
    localparam int unsigned BANK_W           = 10;
    localparam int unsigned LEN_W            = 7;
    localparam int unsigned CMD_W            = 6;
    localparam int unsigned SECTOR_SHIFT     = 9;

    localparam int unsigned DEF_BANK_SECTORS = 32'h007A_7800;
    localparam int unsigned DEF_REG_CAP      = 127;
    localparam int unsigned DEF_BUF_CAP      = 10;
    localparam int unsigned DEF_MAX_ERRS     = 10;
    localparam int unsigned DEF_INT_OFFSET   = 32'h0000_5000;

    localparam logic [CMD_W-1:0] CMD_RD_MULTI = 6'd18;
    localparam logic [CMD_W-1:0] CMD_WR_MULTI = 6'd25;
    localparam logic [CMD_W-1:0] CMD_STOP     = 6'd12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV_GO,
        S_DIV_WAIT,
        S_BANK,
        S_CHUNK,
        S_STOP,
        S_FIN,
        S_FAIL
    } split_state_e;

    typedef struct packed {
        logic [SECTOR_W-1:0] addr;
        logic [LEN_W-1:0]    len;
        logic [CMD_W-1:0]    cmd;
    } chunk_desc_t;

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sector_bank_div.sv
module sector_bank_div #(
    parameter int unsigned SECT_W       = 32,
    parameter int unsigned QUOT_W       = 10,
    parameter int unsigned BANK_SECTORS = 32'h007A_7800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SECT_W-1:0] dividend,
    output logic              fin,
    output logic [QUOT_W-1:0] quot,
    output logic [SECT_W-1:0] rem
);
    localparam logic [SECT_W-1:0] DIVISOR = SECT_W'(BANK_SECTORS);

    logic              run_q;
    logic              fin_q;
    logic [QUOT_W-1:0] quot_q;
    logic [SECT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
            quot_q <= '0;
            rem_q  <= '0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                rem_q  <= dividend;
                quot_q <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (rem_q >= DIVISOR) begin
                    rem_q  <= rem_q - DIVISOR;
                    quot_q <= quot_q + 1'b1;
                end else begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign quot = quot_q;
    assign rem  = rem_q;
endmodule

// File: rtl/sector_chunk_calc.sv
module sector_chunk_calc
    import sector_split_pkg::*;
#(
    parameter int unsigned BANK_SECTORS = DEF_BANK_SECTORS,
    parameter int unsigned REG_CAP      = DEF_REG_CAP,
    parameter int unsigned BUF_CAP      = DEF_BUF_CAP
) (
    input  logic [COUNT_W-1:0]  remaining,
    input  logic [SECTOR_W-1:0] offset,
    input  logic                use_bank,
    input  logic                hc,
    input  logic                write,
    output chunk_desc_t         desc
);
    localparam int unsigned CAP = min_u(REG_CAP, BUF_CAP);
    localparam logic [COUNT_W-1:0] CAP_CNT = COUNT_W'(CAP);

    logic [LEN_W-1:0]    len_capped;
    logic [SECTOR_W-1:0] bank_room;
    logic [LEN_W-1:0]    len_final;

    always_comb begin
        len_capped = (remaining > CAP_CNT) ? LEN_W'(CAP) : remaining[LEN_W-1:0];
        bank_room  = SECTOR_W'(BANK_SECTORS) - offset;
        len_final  = len_capped;
        if (use_bank && (bank_room < SECTOR_W'(len_capped)))
            len_final = bank_room[LEN_W-1:0];
    end

    assign desc.len  = len_final;
    assign desc.addr = hc ? offset : (offset << SECTOR_SHIFT);
    assign desc.cmd  = write ? CMD_WR_MULTI : CMD_RD_MULTI;
endmodule

// File: rtl/sector_splitter.sv
module sector_splitter
    import sector_split_pkg::*;
#(
    parameter int unsigned BANK_SECTORS = DEF_BANK_SECTORS,
    parameter int unsigned REG_CAP      = DEF_REG_CAP,
    parameter int unsigned BUF_CAP      = DEF_BUF_CAP,
    parameter int unsigned MAX_ERRS     = DEF_MAX_ERRS,
    parameter int unsigned INT_OFFSET   = DEF_INT_OFFSET
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SECTOR_W-1:0] req_start,
    input  logic [COUNT_W-1:0]  req_count,
    input  logic                req_write,
    input  logic                req_internal,
    input  logic                req_hc,
    output logic                busy,
    output logic                bank_sel_valid,
    output logic [BANK_W-1:0]   bank_sel_num,
    input  logic                bank_sel_done,
    output logic                chunk_valid,
    output logic [CMD_W-1:0]    chunk_cmd,
    output logic [SECTOR_W-1:0] chunk_addr,
    output logic [LEN_W-1:0]    chunk_len,
    input  logic                chunk_done,
    input  logic                chunk_err,
    output logic                stop_valid,
    output logic [CMD_W-1:0]    stop_cmd,
    output logic                req_done,
    output logic                req_fatal
);
    localparam int unsigned ERR_W = $clog2(MAX_ERRS + 1);
    localparam logic [ERR_W-1:0] ERR_LIMIT = ERR_W'(MAX_ERRS);
    localparam logic [SECTOR_W-1:0] OFFSET_V = SECTOR_W'(INT_OFFSET);

    split_state_e        state_q;
    logic [SECTOR_W-1:0] cur_q;
    logic [COUNT_W-1:0]  left_q;
    logic                wr_q;
    logic                int_q;
    logic                hc_q;
    logic [ERR_W-1:0]    errs_q;
    logic [BANK_W-1:0]   bank_q;
    logic                fail_q;

    logic                div_start;
    logic                div_fin;
    logic [BANK_W-1:0]   div_quot;
    logic [SECTOR_W-1:0] div_rem;
    logic [SECTOR_W-1:0] off_sel;
    chunk_desc_t         desc;

    assign div_start = (state_q == S_DIV_GO) && int_q;
    assign off_sel   = int_q ? div_rem : cur_q;

    sector_bank_div #(
        .SECT_W      (SECTOR_W),
        .QUOT_W      (BANK_W),
        .BANK_SECTORS(BANK_SECTORS)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .start   (div_start),
        .dividend(cur_q),
        .fin     (div_fin),
        .quot    (div_quot),
        .rem     (div_rem)
    );

    sector_chunk_calc #(
        .BANK_SECTORS(BANK_SECTORS),
        .REG_CAP     (REG_CAP),
        .BUF_CAP     (BUF_CAP)
    ) u_calc (
        .remaining(left_q),
        .offset   (off_sel),
        .use_bank (int_q),
        .hc       (hc_q),
        .write    (wr_q),
        .desc     (desc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            left_q  <= '0;
            wr_q    <= 1'b0;
            int_q   <= 1'b0;
            hc_q    <= 1'b0;
            errs_q  <= '0;
            bank_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_q   <= req_start + (req_internal ? OFFSET_V : '0);
                        left_q  <= req_count;
                        wr_q    <= req_write;
                        int_q   <= req_internal;
                        hc_q    <= req_hc;
                        errs_q  <= '0;
                        fail_q  <= 1'b0;
                        state_q <= (req_count == '0) ? S_FIN : S_DIV_GO;
                    end
                end
                S_DIV_GO: begin
                    state_q <= int_q ? S_DIV_WAIT : S_CHUNK;
                end
                S_DIV_WAIT: begin
                    if (div_fin)
                        state_q <= (div_quot != bank_q) ? S_BANK : S_CHUNK;
                end
                S_BANK: begin
                    if (bank_sel_done) begin
                        bank_q  <= div_quot;
                        state_q <= S_CHUNK;
                    end
                end
                S_CHUNK: begin
                    if (chunk_done) begin
                        if (chunk_err) begin
                            if (errs_q == ERR_LIMIT)
                                fail_q <= 1'b1;
                            else
                                errs_q <= errs_q + 1'b1;
                        end else begin
                            cur_q  <= cur_q + SECTOR_W'(desc.len);
                            left_q <= left_q - COUNT_W'(desc.len);
                            errs_q <= '0;
                        end
                        state_q <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (fail_q)
                        state_q <= S_FAIL;
                    else if (left_q == '0)
                        state_q <= S_FIN;
                    else
                        state_q <= S_DIV_GO;
                end
                S_FIN:   state_q <= S_IDLE;
                S_FAIL:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy           = (state_q != S_IDLE);
    assign bank_sel_valid = (state_q == S_BANK);
    assign bank_sel_num   = div_quot;
    assign chunk_valid    = (state_q == S_CHUNK);
    assign chunk_cmd      = desc.cmd;
    assign chunk_addr     = desc.addr;
    assign chunk_len      = desc.len;
    assign stop_valid     = (state_q == S_STOP);
    assign stop_cmd       = CMD_STOP;
    assign req_done       = (state_q == S_FIN);
    assign req_fatal      = (state_q == S_FAIL);
endmodule

// File: rtl/sector_splitter_chk.sv
module sector_splitter_chk
    import sector_split_pkg::*;
#(
    parameter int unsigned BANK_SECTORS = DEF_BANK_SECTORS,
    parameter int unsigned REG_CAP      = DEF_REG_CAP,
    parameter int unsigned BUF_CAP      = DEF_BUF_CAP
) (
    input logic                clk,
    input logic                rst,
    input logic                chunk_valid,
    input logic                chunk_done,
    input logic [SECTOR_W-1:0] chunk_addr,
    input logic [LEN_W-1:0]    chunk_len,
    input logic [CMD_W-1:0]    chunk_cmd,
    input logic                bank_sel_valid,
    input logic                stop_valid,
    input logic                req_done,
    input logic                req_fatal,
    input logic                use_bank,
    input logic [SECTOR_W-1:0] bank_off
);
    localparam int unsigned CAP = min_u(REG_CAP, BUF_CAP);

    assert_len_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> (chunk_len != '0) && (int'(chunk_len) <= int'(CAP)));

    assert_bank_clip_R4: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && use_bank) |->
            ({1'b0, bank_off} + (SECTOR_W+1)'(chunk_len) <= (SECTOR_W+1)'(BANK_SECTORS)));

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(bank_sel_valid && chunk_valid));

    assert_stop_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        stop_valid |-> $past(chunk_valid && chunk_done));

    assert_desc_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && !chunk_done) |=>
            (chunk_valid && $stable(chunk_addr) && $stable(chunk_len) && $stable(chunk_cmd)));

    assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_done && req_fatal));
endmodule

bind sector_splitter sector_splitter_chk #(
    .BANK_SECTORS(BANK_SECTORS),
    .REG_CAP     (REG_CAP),
    .BUF_CAP     (BUF_CAP)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chunk_valid   (chunk_valid),
    .chunk_done    (chunk_done),
    .chunk_addr    (chunk_addr),
    .chunk_len     (chunk_len),
    .chunk_cmd     (chunk_cmd),
    .bank_sel_valid(bank_sel_valid),
    .stop_valid    (stop_valid),
    .req_done      (req_done),
    .req_fatal     (req_fatal),
    .use_bank      (int_q),
    .bank_off      (off_sel)
);

// File: tb/sector_splitter_test.sv
`timescale 1ns/100ps
module sector_splitter_test;
    localparam longint BANK = 64'h7A7800;
    localparam longint OFF  = 64'h5000;
    localparam int     CAP  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_start = '0;
    logic [15:0] req_count = '0;
    logic        req_write = 1'b0;
    logic        req_internal = 1'b0;
    logic        req_hc = 1'b0;
    logic        busy;
    logic        bank_sel_valid;
    logic [9:0]  bank_sel_num;
    logic        bank_sel_done = 1'b0;
    logic        chunk_valid;
    logic [5:0]  chunk_cmd;
    logic [31:0] chunk_addr;
    logic [6:0]  chunk_len;
    logic        chunk_done = 1'b0;
    logic        chunk_err = 1'b0;
    logic        stop_valid;
    logic [5:0]  stop_cmd;
    logic        req_done;
    logic        req_fatal;

    always #2.5 clk = ~clk;

    sector_splitter uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_start(req_start),
        .req_count(req_count), .req_write(req_write), .req_internal(req_internal),
        .req_hc(req_hc), .busy(busy), .bank_sel_valid(bank_sel_valid),
        .bank_sel_num(bank_sel_num), .bank_sel_done(bank_sel_done),
        .chunk_valid(chunk_valid), .chunk_cmd(chunk_cmd), .chunk_addr(chunk_addr),
        .chunk_len(chunk_len), .chunk_done(chunk_done), .chunk_err(chunk_err),
        .stop_valid(stop_valid), .stop_cmd(stop_cmd), .req_done(req_done),
        .req_fatal(req_fatal)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // observed run
    int          n_chunks, n_stops, n_sels, bad_stop_cmd;
    bit          saw_done, saw_fatal, stab_bad;
    logic [31:0] got_addr [32];
    int          got_len  [32];
    int          got_cmd  [32];
    int          got_sel  [32];
    // expected run
    int          exp_n;
    logic [31:0] exp_addr [32];
    int          exp_len  [32];
    int          exp_cmd  [32];
    int          exp_sel  [32];
    longint      model_bank = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] s, input int cnt, input bit wr,
                         input bit intl, input bit hc);
        @(negedge clk);
        req_start = s; req_count = 16'(cnt); req_write = wr;
        req_internal = intl; req_hc = hc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Services bank-select and chunk handshakes; fails the first n_err chunks.
    task automatic serve(input int n_err);
        int errs_left;
        int hold;
        int pend_sel;
        errs_left = n_err; hold = 0; pend_sel = -1;
        n_chunks = 0; n_stops = 0; n_sels = 0; bad_stop_cmd = 0;
        saw_done = 0; saw_fatal = 0; stab_bad = 0;
        for (int cyc = 0; cyc < 4000 && !saw_done && !saw_fatal; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (stop_valid) begin
                n_stops++;
                if (stop_cmd != 6'd12) bad_stop_cmd++;
            end
            if (req_done) saw_done = 1;
            if (req_fatal) saw_fatal = 1;
            if (bank_sel_done || chunk_done) begin
                bank_sel_done = 1'b0; chunk_done = 1'b0; chunk_err = 1'b0;
            end else if (bank_sel_valid) begin
                pend_sel = int'(bank_sel_num);
                n_sels++;
                bank_sel_done = 1'b1;
            end else if (chunk_valid && n_chunks < 32) begin
                if (hold == 0) begin
                    got_addr[n_chunks] = chunk_addr;
                    got_len[n_chunks]  = int'(chunk_len);
                    got_cmd[n_chunks]  = int'(chunk_cmd);
                    got_sel[n_chunks]  = pend_sel;
                    pend_sel = -1;
                end else if (chunk_addr != got_addr[n_chunks] ||
                             int'(chunk_len) != got_len[n_chunks] ||
                             int'(chunk_cmd) != got_cmd[n_chunks]) begin
                    stab_bad = 1;
                end
                hold++;
                if (hold == 3) begin
                    chunk_done = 1'b1;
                    chunk_err  = (errs_left > 0);
                    if (errs_left > 0) errs_left--;
                    n_chunks++;
                    hold = 0;
                end
            end
        end
    endtask

    task automatic model(input longint s, input int cnt, input bit wr,
                         input bit intl, input bit hc);
        longint cur, off, bank, len;
        int rem;
        cur = (s + (intl ? OFF : 0)) & 64'hFFFF_FFFF;
        rem = cnt; exp_n = 0;
        while (rem > 0 && exp_n < 32) begin
            exp_sel[exp_n] = -1;
            if (intl) begin
                bank = cur / BANK;
                off  = cur % BANK;
                if (bank != model_bank) exp_sel[exp_n] = int'(bank);
                model_bank = bank;
            end else begin
                off = cur;
            end
            len = (rem < CAP) ? rem : CAP;
            if (intl && len > BANK - off) len = BANK - off;
            exp_addr[exp_n] = hc ? 32'(off) : 32'(off * 512);
            exp_len[exp_n]  = int'(len);
            exp_cmd[exp_n]  = wr ? 25 : 18;
            exp_n++;
            cur += len;
            rem -= int'(len);
        end
    endtask

    task automatic compare(input string tag);
        chk(n_chunks == exp_n, {tag, " chunk count"}, n_chunks, exp_n);
        for (int i = 0; i < exp_n && i < n_chunks; i++) begin
            chk(got_addr[i] == exp_addr[i], {tag, " addr"}, got_addr[i], exp_addr[i]);
            chk(got_len[i] == exp_len[i], {tag, " len"}, got_len[i], exp_len[i]);
            chk(got_cmd[i] == exp_cmd[i], {tag, " cmd R6"}, got_cmd[i], exp_cmd[i]);
            chk(got_sel[i] == exp_sel[i], {tag, " bank select R3"}, got_sel[i], exp_sel[i]);
        end
        chk(n_stops == exp_n && bad_stop_cmd == 0, {tag, " stops R6"}, n_stops, exp_n);
        chk(saw_done && !saw_fatal, {tag, " done"}, saw_done, 1);
        chk(!stab_bad, {tag, " stable R7"}, stab_bad, 0);
    endtask

    task automatic run_clean(input string tag, input longint s, input int cnt,
                             input bit wr, input bit intl, input bit hc);
        issue(32'(s), cnt, wr, intl, hc);
        serve(0);
        model(s, cnt, wr, intl, hc);
        compare(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !chunk_valid && !bank_sel_valid && !stop_valid && !req_done && !req_fatal,
            "R11 reset idle", {busy, chunk_valid, bank_sel_valid, stop_valid, req_done, req_fatal}, 0);
    endtask

    task automatic t_ext_read_hc();
        run_clean("R1 R8 external read split", 100, 25, 0, 0, 1);
    endtask

    task automatic t_ext_write_sd();
        run_clean("R5 external write byte address", 3, 4, 1, 0, 0);
    endtask

    task automatic t_int_cross();
        run_clean("R2 R4 internal bank crossing", BANK - 3 - OFF, 7, 0, 1, 1);
        chk(n_sels == 1, "R3 one select on crossing", n_sels, 1);
    endtask

    task automatic t_int_same_bank();
        run_clean("R3 R5 internal same bank", BANK + 7 - OFF, 2, 1, 1, 0);
        chk(n_sels == 0, "R3 no redundant select", n_sels, 0);
    endtask

    task automatic t_int_back();
        run_clean("R2 R3 internal back to bank 0", 0, 1, 0, 1, 1);
        chk(n_sels == 1, "R3 select bank 0 again", n_sels, 1);
    endtask

    task automatic t_retry();
        issue(32'd50, 3, 0, 0, 1);
        serve(3);
        chk(n_chunks == 4 && saw_done && !saw_fatal, "R8 retry count", n_chunks, 4);
        for (int i = 0; i < 4 && i < n_chunks; i++)
            chk(got_addr[i] == 32'd50 && got_len[i] == 3, "R8 retry same chunk", got_addr[i], 50);
        chk(n_stops == 4, "R6 stop per attempt", n_stops, 4);
    endtask

    task automatic t_limit();
        issue(32'd9, 2, 1, 0, 1);
        serve(10);
        chk(saw_done && !saw_fatal, "R9 ten errors still retried", saw_fatal, 0);
        chk(n_chunks == 11, "R9 attempts at limit", n_chunks, 11);
    endtask

    task automatic t_fatal();
        issue(32'd20, 5, 0, 0, 1);
        serve(11);
        chk(saw_fatal && !saw_done, "R9 fatal on eleventh error", saw_fatal, 1);
        chk(n_chunks == 11 && n_stops == 11, "R9 attempts before fatal", n_chunks, 11);
        repeat (3) @(negedge clk);
        chk(!busy && !chunk_valid, "R9 idle after fatal", busy, 0);
    endtask

    task automatic t_zero();
        issue(32'd77, 0, 0, 0, 1);
        serve(0);
        chk(saw_done && n_chunks == 0 && n_stops == 0, "R10 zero count", n_chunks, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ext_read_hc();
        t_ext_write_sd();
        t_int_cross();
        t_int_same_bank();
        t_int_back();
        t_retry();
        t_limit();
        t_fatal();
        t_zero();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule